// File: doc/BRIEF.md
# Operand Address Generator

This block turns one decoded operand specifier into an effective memory address. Each request carries a 3-bit addressing mode, a base register selector, an index register selector, a signed displacement and an absolute address field. The block reads the base and index values from its own small file of address registers, forms the address in one cycle, and reports whether the operand lives in memory at all. For immediate and register-direct operands no address is produced.

The two stepping modes also change the base register. Post-increment returns the old register value as the address and then advances the register by a fixed step. Pre-decrement lowers the register by the step first and returns the lowered value as the address. The new register value is written in the same clock edge that accepts the request, so a request in the very next cycle already sees it. A registered write-back pulse names the register and its new value. A separate load port lets the surrounding pipeline set register contents.

Top module: `opnd_agu`

## Requirements
- R1: After reset, res_valid and wb_valid are low, res_ea is zero, and every address register holds zero.
- R2: Mode 0 (immediate) and mode 1 (register direct) give res_mem = 0 and res_ea = 0, and they raise no write-back.
- R3: Mode 2 (absolute) gives res_ea equal to req_abs and res_mem = 1.
- R4: Mode 3 (register indirect) gives res_ea equal to the base register's value.
- R5: Mode 4 (post-increment) gives the base register's old value as res_ea and stores old value + STEP (default 2) into the base register.
- R6: Mode 5 (pre-decrement) stores base − STEP into the base register and gives that new value as res_ea.
- R7: Mode 6 (displacement) gives base plus req_disp, where req_disp is sign-extended from DISP_W bits to the address width.
- R8: Mode 7 (indexed) gives base plus index register plus sign-extended req_disp.
- R9: A request with req_valid high at a rising edge shows its results on res_valid, res_ea and res_mem for the following cycle. Modes 4 and 5 also pulse wb_valid in that cycle, with wb_sel and wb_addr naming the register and its new value. A request in the next cycle reads the updated register.
- R10: When a write-back and a load target the same register at the same edge, the write-back value is the one stored.
- R11: All address arithmetic wraps modulo 2^ADDR_W.
- R12: While req_valid is low, res_valid and wb_valid fall low on the next edge and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load an address register |
| ld_sel | input | SEL_W | Register to load |
| ld_addr | input | ADDR_W | Value to load |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode 0..7 |
| req_base | input | SEL_W | Base register selector |
| req_index | input | SEL_W | Index register selector |
| req_disp | input | DISP_W | Signed displacement |
| req_abs | input | ADDR_W | Absolute address field |
| res_valid | output | 1 | Result valid |
| res_ea | output | ADDR_W | Effective address |
| res_mem | output | 1 | Operand is in memory |
| wb_valid | output | 1 | Base register write-back pulse |
| wb_sel | output | SEL_W | Register written back |
| wb_addr | output | ADDR_W | Value written back |

## Verification
The hardest cases to reach are two stepping requests on the same register in consecutive cycles, and a load that collides with a write-back on one register. Both depend on the acceptance edge and cannot be seen from a single request. The stimulus drives two post-increments back to back with no idle cycle between them. It also raises the load port in the same cycle as a post-increment to that register, then reads the register back through an indirect request. Wrap-around is reached by loading 0 and 0xFFFF into registers before stepping them.

// File: rtl/opnd_agu_pkg.sv
package opnd_agu_pkg;
   typedef enum logic [2:0] {
      AM_IMM     = 3'd0,
      AM_REG     = 3'd1,
      AM_ABS     = 3'd2,
      AM_IND     = 3'd3,
      AM_POSTINC = 3'd4,
      AM_PREDEC  = 3'd5,
      AM_DISP    = 3'd6,
      AM_INDEX   = 3'd7
   } am_e;
endpackage

// File: rtl/opnd_agu_regfile.sv
module opnd_agu_regfile #(
   parameter int ADDR_W = 16,
   parameter int NREG   = 8,
   localparam int SEL_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [ADDR_W-1:0] ld_data,
   input  logic              up_en,
   input  logic [SEL_W-1:0]  up_sel,
   input  logic [ADDR_W-1:0] up_data,
   input  logic [SEL_W-1:0]  rd_a_sel,
   input  logic [SEL_W-1:0]  rd_b_sel,
   output logic [ADDR_W-1:0] rd_a,
   output logic [ADDR_W-1:0] rd_b
);
   logic [ADDR_W-1:0] regs_q [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[g] <= '0;
         else if (up_en && up_sel == SEL_W'(g))
            regs_q[g] <= up_data;
         else if (ld_en && ld_sel == SEL_W'(g))
            regs_q[g] <= ld_data;
      end
   end

   assign rd_a = regs_q[rd_a_sel];
   assign rd_b = regs_q[rd_b_sel];

   AST_UPDATE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (up_en && ld_en && up_sel == ld_sel) |=> (regs_q[$past(up_sel)] == $past(up_data))); // R10
endmodule

// File: rtl/opnd_agu_calc.sv
module opnd_agu_calc
   import opnd_agu_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DISP_W      = 8,
   parameter int STEP        = 2,
   parameter bit DISP_SIGNED = 1'b1
) (
   input  am_e               mode,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [ADDR_W-1:0] idx_val,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] abs_addr,
   output logic [ADDR_W-1:0] ea,
   output logic              is_mem,
   output logic              upd,
   output logic [ADDR_W-1:0] upd_val
);
   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] base_inc, base_dec;

   if (DISP_SIGNED) begin : g_sext
      assign disp_ext = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
   end else begin : g_zext
      assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, disp};
   end

   assign base_inc = base_val + STEP_V;
   assign base_dec = base_val - STEP_V;

   always_comb begin
      ea      = '0;
      is_mem  = 1'b1;
      upd     = 1'b0;
      upd_val = base_val;
      unique case (mode)
         AM_IMM, AM_REG: is_mem = 1'b0;
         AM_ABS:         ea = abs_addr;
         AM_IND:         ea = base_val;
         AM_POSTINC: begin
            ea      = base_val;
            upd     = 1'b1;
            upd_val = base_inc;
         end
         AM_PREDEC: begin
            ea      = base_dec;
            upd     = 1'b1;
            upd_val = base_dec;
         end
         AM_DISP:        ea = base_val + disp_ext;
         AM_INDEX:       ea = base_val + idx_val + disp_ext;
         default:        is_mem = 1'b0;
      endcase
   end
endmodule

// File: rtl/opnd_agu.sv
module opnd_agu
   import opnd_agu_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int NREG        = 8,
   parameter int DISP_W      = 8,
   parameter int STEP        = 2,
   parameter bit DISP_SIGNED = 1'b1,
   localparam int SEL_W      = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [SEL_W-1:0]  ld_sel,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic [SEL_W-1:0]  req_base,
   input  logic [SEL_W-1:0]  req_index,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [ADDR_W-1:0] req_abs,
   output logic              res_valid,
   output logic [ADDR_W-1:0] res_ea,
   output logic              res_mem,
   output logic              wb_valid,
   output logic [SEL_W-1:0]  wb_sel,
   output logic [ADDR_W-1:0] wb_addr
);
   if (ADDR_W < 4)                     begin : g_chk_aw   $error("ADDR_W too small"); end
   if (NREG < 2 || (1 << SEL_W) != NREG) begin : g_chk_nr $error("NREG must be a power of two >= 2"); end
   if (DISP_W < 1 || DISP_W >= ADDR_W) begin : g_chk_dw   $error("DISP_W must be 1..ADDR_W-1"); end
   if (STEP < 1)                       begin : g_chk_st   $error("STEP must be positive"); end

   logic [ADDR_W-1:0] base_val, idx_val, ea_c, upd_val_c;
   logic              mem_c, upd_c;
   am_e               mode_c, mode_q;

   assign mode_c = am_e'(req_mode);

   opnd_agu_regfile #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rf (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_en    (ld_en),
      .ld_sel   (ld_sel),
      .ld_data  (ld_addr),
      .up_en    (req_valid && upd_c),
      .up_sel   (req_base),
      .up_data  (upd_val_c),
      .rd_a_sel (req_base),
      .rd_b_sel (req_index),
      .rd_a     (base_val),
      .rd_b     (idx_val)
   );

   opnd_agu_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .STEP(STEP),
                   .DISP_SIGNED(DISP_SIGNED)) u_calc (
      .mode     (mode_c),
      .base_val (base_val),
      .idx_val  (idx_val),
      .disp     (req_disp),
      .abs_addr (req_abs),
      .ea       (ea_c),
      .is_mem   (mem_c),
      .upd      (upd_c),
      .upd_val  (upd_val_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_ea    <= '0;
         res_mem   <= 1'b0;
         mode_q    <= AM_IMM;
         wb_valid  <= 1'b0;
         wb_sel    <= '0;
         wb_addr   <= '0;
      end else begin
         res_valid <= req_valid;
         wb_valid  <= req_valid && upd_c;
         if (req_valid) begin
            res_ea  <= ea_c;
            res_mem <= mem_c;
            mode_q  <= mode_c;
            wb_sel  <= req_base;
            wb_addr <= upd_val_c;
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!res_valid && !wb_valid)); // R12
   AST_NONMEM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_mem) |-> (res_ea == '0 && !wb_valid)); // R2
   AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && mode_q == AM_POSTINC) |-> (wb_addr == res_ea + ADDR_W'(STEP))); // R5
   AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_valid && mode_q == AM_PREDEC) |-> (wb_addr == res_ea)); // R6
   AST_WB_WITH_RES: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> (res_valid && res_mem)); // R9
endmodule

// File: tb/opnd_agu_tb.sv
module opnd_agu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [2:0]  ld_sel = '0;
   logic [15:0] ld_addr = '0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0, req_base = '0, req_index = '0;
   logic [7:0]  req_disp = '0;
   logic [15:0] req_abs = '0;
   logic        res_valid, res_mem, wb_valid;
   logic [15:0] res_ea, wb_addr;
   logic [2:0]  wb_sel;

   int errors = 0, checks = 0;

   always #5 clk = ~clk;

   opnd_agu u_dut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr),
      .req_valid(req_valid), .req_mode(req_mode), .req_base(req_base),
      .req_index(req_index), .req_disp(req_disp), .req_abs(req_abs),
      .res_valid(res_valid), .res_ea(res_ea), .res_mem(res_mem),
      .wb_valid(wb_valid), .wb_sel(wb_sel), .wb_addr(wb_addr)
   );

   // {mode, base, idx, disp, abs, exp_ea, exp_mem, exp_wb, exp_wbdata}
   localparam int NV = 13;
   localparam logic [66:0] VEC [NV] = '{
      {3'd0, 3'd1, 3'd0, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2
      {3'd1, 3'd2, 3'd0, 8'h00, 16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000}, // R2
      {3'd2, 3'd0, 3'd0, 8'h00, 16'h2345, 16'h2345, 1'b1, 1'b0, 16'h0000}, // R3
      {3'd3, 3'd3, 3'd0, 8'h00, 16'h0000, 16'h1300, 1'b1, 1'b0, 16'h0000}, // R4
      {3'd4, 3'd4, 3'd0, 8'h00, 16'h0000, 16'h1400, 1'b1, 1'b1, 16'h1402}, // R5
      {3'd3, 3'd4, 3'd0, 8'h00, 16'h0000, 16'h1402, 1'b1, 1'b0, 16'h0000}, // R5
      {3'd5, 3'd5, 3'd0, 8'h00, 16'h0000, 16'h14FE, 1'b1, 1'b1, 16'h14FE}, // R6
      {3'd3, 3'd5, 3'd0, 8'h00, 16'h0000, 16'h14FE, 1'b1, 1'b0, 16'h0000}, // R6
      {3'd6, 3'd6, 3'd0, 8'h10, 16'h0000, 16'h1610, 1'b1, 1'b0, 16'h0000}, // R7
      {3'd6, 3'd6, 3'd0, 8'hF0, 16'h0000, 16'h15F0, 1'b1, 1'b0, 16'h0000}, // R7
      {3'd7, 3'd1, 3'd2, 8'h08, 16'h0000, 16'h2308, 1'b1, 1'b0, 16'h0000}, // R8
      {3'd7, 3'd7, 3'd7, 8'h80, 16'h0000, 16'h2D80, 1'b1, 1'b0, 16'h0000}, // R8
      {3'd5, 3'd0, 3'd0, 8'h00, 16'h0000, 16'h0FFE, 1'b1, 1'b1, 16'h0FFE}  // R6
   };

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive at negedge, accepted at next posedge, sampled at following negedge
   task automatic issue(input logic [2:0] m, input logic [2:0] b, input logic [2:0] x,
                        input logic [7:0] d, input logic [15:0] a);
      req_valid = 1'b1; req_mode = m; req_base = b; req_index = x; req_disp = d; req_abs = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic load(input logic [2:0] s, input logic [15:0] v);
      ld_en = 1'b1; ld_sel = s; ld_addr = v;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (2) @(negedge clk);
      chk("R1 res_valid", 32'(res_valid), 0);
      chk("R1 wb_valid", 32'(wb_valid), 0);
      chk("R1 res_ea", 32'(res_ea), 0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(3'd3, 3'd1, 3'd0, 8'h00, 16'h0000);
      chk("R1 reg zero after reset", 32'(res_ea), 0);
      @(negedge clk);

      for (int i = 0; i < 8; i++) load(3'(i), 16'h1000 + 16'(i) * 16'h0100);

      for (int i = 0; i < NV; i++) begin
         logic [66:0] v;
         v = VEC[i];
         issue(v[66:64], v[63:61], v[60:58], v[57:50], v[49:34]);
         chk($sformatf("R9 vec%0d valid", i), 32'(res_valid), 1);
         chk($sformatf("vec%0d ea (R2-R8)", i), 32'(res_ea), 32'(v[33:18]));
         chk($sformatf("vec%0d mem (R2)", i), 32'(res_mem), 32'(v[17]));
         chk($sformatf("R9 vec%0d wb_valid", i), 32'(wb_valid), 32'(v[16]));
         if (v[16]) begin
            chk($sformatf("R9 vec%0d wb_addr", i), 32'(wb_addr), 32'(v[15:0]));
            chk($sformatf("R9 vec%0d wb_sel", i), 32'(wb_sel), 32'(v[63:61]));
         end
         @(negedge clk);
         chk($sformatf("R12 vec%0d idle", i), 32'({res_valid, wb_valid}), 0);
      end

      // R9: back-to-back post-increment on r3 (1300)
      req_valid = 1'b1; req_mode = 3'd4; req_base = 3'd3;
      @(negedge clk);
      chk("R9 b2b first ea", 32'(res_ea), 32'h1300);
      chk("R9 b2b first wb", 32'(wb_addr), 32'h1302);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 b2b second ea", 32'(res_ea), 32'h1302);
      chk("R9 b2b second wb", 32'(wb_addr), 32'h1304);
      @(negedge clk);

      // R10: load and post-increment hit r2 at the same edge
      ld_en = 1'b1; ld_sel = 3'd2; ld_addr = 16'h5555;
      issue(3'd4, 3'd2, 3'd0, 8'h00, 16'h0000);
      ld_en = 1'b0;
      chk("R10 collide ea", 32'(res_ea), 32'h1200);
      issue(3'd3, 3'd2, 3'd0, 8'h00, 16'h0000);
      chk("R10 write-back wins", 32'(res_ea), 32'h1202);

      // R11: wrap-around both ways
      load(3'd0, 16'h0000);
      issue(3'd5, 3'd0, 3'd0, 8'h00, 16'h0000);
      chk("R11 predec wrap ea", 32'(res_ea), 32'hFFFE);
      load(3'd6, 16'hFFFF);
      issue(3'd4, 3'd6, 3'd0, 8'h00, 16'h0000);
      chk("R11 postinc wrap wb", 32'(wb_addr), 32'h0001);
      issue(3'd6, 3'd6, 3'd0, 8'hFE, 16'h0000);
      chk("R11 disp wrap ea", 32'(res_ea), 32'hFFFF);

      // R12: several idle cycles leave r5 untouched
      req_mode = 3'd5; req_base = 3'd5;
      repeat (3) @(negedge clk);
      chk("R12 idle no valid", 32'(res_valid), 0);
      issue(3'd3, 3'd5, 3'd0, 8'h00, 16'h0000);
      chk("R12 r5 unchanged", 32'(res_ea), 32'h14FE);

      // R1: reset mid-run clears registers
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset res_valid", 32'(res_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(3'd3, 3'd4, 3'd0, 8'h00, 16'h0000);
      chk("R1 reg cleared", 32'(res_ea), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule